// File: doc/BRIEF.md
# Secured Sector Protection Controller

This block holds the command logic for a small one-time-programmable sector that sits beside a larger flash-style memory. Software talks to it over a plain synchronous bus: a write strobe with address and data, and a read strobe whose byte appears on the read-data port one clock later. A command byte opens the secured region. Inside the region the sector can be read and programmed, and a two-write sequence locks it for good. A status read then tells software whether the lock took effect.

The lock is one-way. No bus command clears it, and the bus reset does not clear it either. Only a dedicated power-on initialisation input returns the lock flag and the sector contents to their blank state. Once the lock is set, programming the sector has no effect. After a bus reset, a startup window of a fixed number of clocks must pass before any command write is accepted.

Command codes are 88h (enter region), 90h followed by 00h (leave region), A0h followed by a data write (program one sector byte), 60h followed by 40h (protect), and F0h (end the verify mode). The secured window is the set of addresses whose bits above the sector index are all zero. The status pattern is any address with bit 6 = 0, bit 1 = 1 and bit 0 = 0.

Top module: `ssp_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the cycle after its release, `rdata` is 00h and `in_region` is 0.
- R2: For WAIT_CYC clocks after `rst_n` is released, every write is ignored: a write of 88h in that window leaves `in_region` at 0.
- R3: A write of 88h sets `in_region`. A write of 90h followed by a write of 00h clears it. With `in_region` at 0, every read returns FFh.
- R4: With `in_region` at 1 and the sector unlocked, a write of A0h followed by a data write to a secured-window address stores the data byte at index addr[IDX_W-1:0]. A read of that address outside verify mode returns the stored byte.
- R5: Inside the region, a write of 60h followed by a write of 40h to a status-pattern address (bit6=0, bit1=1, bit0=0) sets the lock and enters verify mode. A status-pattern read then returns 01h.
- R6: After 60h alone (verify armed), a status-pattern read returns 00h while the sector is unlocked.
- R7: After 60h, a write that is not 40h to a status-pattern address returns the controller to idle without locking. The next status-pattern read then returns sector data.
- R8: In verify mode a write of F0h ends verify mode. Status-pattern reads then return sector data again, and `in_region` is unchanged.
- R9: Once locked, the lock stays set through F0h, leaving and re-entering the region, and pulses of `rst_n`. A program sequence leaves the sector contents unchanged.
- R10: A `por_init` pulse clears the lock and sets every sector byte to FFh.
- R11: In the region, a read that is outside verify mode or does not hit the status pattern returns the sector byte for a secured-window address, and FFh for any other address.
- R12: `rdata` changes only on the clock edge at which `rd_en` is sampled high; otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low bus reset |
| por_init | input | 1 | Power-on initialisation of the lock flag and the sector contents |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Write data or command byte |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, registered one clock after `rd_en` |
| in_region | output | 1 | High while the secured region is open |

## Verification
The embedded assertions check on every cycle that the lock never falls without `por_init` and that it only rises together with entry into verify mode. They also check that no sector write happens while locked, that writes inside the startup window leave `in_region` unchanged, and that `rdata` holds between reads. The bench scenarios are what show the values: sector contents read back after programming, the 00h and 01h status bytes, the abort of every wrong address-bit combination, lock survival across bus resets, and the blanking done by `por_init`.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ARM    = 3'd1,
    ST_VERIFY = 3'd2,
    ST_PROG   = 3'd3,
    ST_EXIT   = 3'd4
  } ssp_state_e;

  localparam logic [7:0] CMD_ENTER = 8'h88;
  localparam logic [7:0] CMD_LEAVE = 8'h90;
  localparam logic [7:0] CMD_LEAVE2 = 8'h00;
  localparam logic [7:0] CMD_ARM   = 8'h60;
  localparam logic [7:0] CMD_LOCK  = 8'h40;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_RESET = 8'hF0;
  localparam logic [7:0] BLANK     = 8'hFF;
endpackage

// File: rtl/ssp_startup_gate.sv
module ssp_startup_gate #(
  parameter int WAIT_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic gate_open
);
  localparam int CW = $clog2(WAIT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WAIT_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign gate_open = (cnt_q == LIMIT);
  assign cnt_en    = !gate_open;

  always_comb begin
    cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R2
  gate_stays_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_open |=> gate_open);
endmodule

// File: rtl/ssp_cmd_fsm.sv
module ssp_cmd_fsm
  import ssp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_init,
  input  logic       gate_open,
  input  logic       wr_en,
  input  logic       pat_hit,
  input  logic       win_hit,
  input  logic [7:0] wdata,
  output logic       in_region,
  output logic       locked,
  output logic       verify_mode,
  output logic       prog_we
);
  ssp_state_e st_q, st_d;
  logic       reg_d, lock_set, wr_acc;

  assign wr_acc      = wr_en && gate_open;
  assign verify_mode = (st_q == ST_ARM) || (st_q == ST_VERIFY);
  assign prog_we     = wr_acc && (st_q == ST_PROG) && in_region && win_hit && !locked;

  always_comb begin
    st_d     = st_q;
    reg_d    = in_region;
    lock_set = 1'b0;
    if (wr_acc) begin
      unique case (st_q)
        ST_IDLE: begin
          if (wdata == CMD_ENTER)                     reg_d = 1'b1;
          else if (wdata == CMD_LEAVE && in_region)   st_d = ST_EXIT;
          else if (wdata == CMD_ARM && in_region)     st_d = ST_ARM;
          else if (wdata == CMD_PROG && in_region && !locked) st_d = ST_PROG;
        end
        ST_ARM: begin
          if (wdata == CMD_LOCK && pat_hit) begin
            lock_set = 1'b1;
            st_d     = ST_VERIFY;
          end else begin
            st_d = ST_IDLE;
          end
        end
        ST_VERIFY: if (wdata == CMD_RESET) st_d = ST_IDLE;
        ST_PROG:   st_d = ST_IDLE;
        ST_EXIT: begin
          if (wdata == CMD_LEAVE2) reg_d = 1'b0;
          st_d = ST_IDLE;
        end
        default:   st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      in_region <= 1'b0;
    end else begin
      st_q      <= st_d;
      in_region <= reg_d;
    end
  end

  // Lock flag: untouched by the bus reset, only power-on init clears it.
  always_ff @(posedge clk) begin
    if (por_init)      locked <= 1'b0;
    else if (lock_set) locked <= 1'b1;
  end

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(por_init));
  // R5
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (st_q == ST_VERIFY));
  // R2
  startup_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_open |=> $stable(in_region));
endmodule

// File: rtl/ssp_otp_array.sv
module ssp_otp_array #(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     por_init,
  input  logic                     locked,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] widx,
  input  logic [7:0]               wdata,
  input  logic [$clog2(DEPTH)-1:0] ridx,
  output logic [7:0]               rdout
);
  logic [7:0] mem_q [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      logic cell_we;
      assign cell_we = we && (widx == ($clog2(DEPTH))'(i));
      always_ff @(posedge clk) begin
        if (por_init)     mem_q[i] <= ssp_pkg::BLANK;
        else if (cell_we) mem_q[i] <= wdata;
      end
    end
  endgenerate

  assign rdout = mem_q[ridx];

  // R9
  prog_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !locked);
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DEPTH    = 16,
  parameter int WAIT_CYC = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_init,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  output logic              in_region
);
  localparam int IDX_W = $clog2(DEPTH);

  logic             gate_open, locked, verify_mode, prog_we;
  logic             pat_hit, win_hit;
  logic [7:0]       cell_q, rd_d;
  logic [IDX_W-1:0] idx;

  assign idx     = addr[IDX_W-1:0];
  assign pat_hit = !addr[6] && addr[1] && !addr[0];
  assign win_hit = (addr[ADDR_W-1:IDX_W] == '0);

  ssp_startup_gate #(.WAIT_CYC(WAIT_CYC)) gate_i (
    .clk(clk), .rst_n(rst_n), .gate_open(gate_open)
  );

  ssp_cmd_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .por_init(por_init), .gate_open(gate_open),
    .wr_en(wr_en), .pat_hit(pat_hit), .win_hit(win_hit), .wdata(wdata),
    .in_region(in_region), .locked(locked), .verify_mode(verify_mode),
    .prog_we(prog_we)
  );

  ssp_otp_array #(.DEPTH(DEPTH)) arr_i (
    .clk(clk), .rst_n(rst_n), .por_init(por_init), .locked(locked),
    .we(prog_we), .widx(idx), .wdata(wdata), .ridx(idx), .rdout(cell_q)
  );

  always_comb begin
    if (!in_region)                rd_d = BLANK;
    else if (verify_mode && pat_hit) rd_d = {7'b0, locked};
    else if (win_hit)              rd_d = cell_q;
    else                           rd_d = BLANK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= 8'h00;
    else if (rd_en) rdata <= rd_d;
  end

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
  // R3
  outside_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !in_region) |=> (rdata == BLANK));
endmodule

// File: tb/ssp_ctrl_tb_top.sv
module ssp_ctrl_tb_top;
  localparam int ADDR_W = 8;
  localparam int DEPTH = 16;
  localparam int WAIT_CYC = 100;

  logic clk = 1'b0;
  logic rst_n, por_init, wr_en, rd_en, in_region;
  logic [ADDR_W-1:0] addr;
  logic [7:0] wdata, rdata, got;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ssp_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .WAIT_CYC(WAIT_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .por_init(por_init), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .in_region(in_region)
  );

  function automatic logic [7:0] pat_val(int i);
    return 8'((i * 7 + 3) & 8'hFF);
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_reset();
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(WAIT_CYC + 2);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; por_init = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wdata = '0;
    idle(3);
    por_init = 1'b0;
    idle(1);
    check("R1 rdata in reset", rdata, 8'h00);
    check("R1 region in reset", {7'b0, in_region}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata after release", rdata, 8'h00);
    // R2: write inside the startup window is dropped
    wr(8'h00, 8'h88);
    check("R2 early enter ignored", {7'b0, in_region}, 8'h00);
    idle(WAIT_CYC + 2);
    check("R2 region still closed", {7'b0, in_region}, 8'h00);
    rd(8'h05, got); check("R3 read outside region", got, 8'hFF);

    wr(8'h00, 8'h88);
    check("R3 enter region", {7'b0, in_region}, 8'h01);
    rd(8'h05, got); check("R10 blank after init", got, 8'hFF);

    // R4: program every sector byte then read all back
    for (int i = 0; i < DEPTH; i++) begin
      wr(8'h00, 8'hA0);
      wr(8'(i), pat_val(i));
    end
    for (int i = 0; i < DEPTH; i++) begin
      rd(8'(i), got); check("R4 readback", got, pat_val(i));
    end
    // R11: address outside secured window
    rd(8'h46, got); check("R11 outside window", got, 8'hFF);

    // R3: leave region
    wr(8'h00, 8'h90); wr(8'h00, 8'h00);
    check("R3 leave region", {7'b0, in_region}, 8'h00);
    rd(8'h02, got); check("R3 read after leave", got, 8'hFF);
    wr(8'h00, 8'h88);
    check("R3 reenter", {7'b0, in_region}, 8'h01);

    // R7: sweep all pattern-bit combinations except the valid one
    for (int k = 0; k < 8; k++) begin
      if (k != 2) begin
        wr(8'h00, 8'h60);
        wr(8'h10 | 8'((k >> 2) & 1) << 6 | 8'((k >> 1) & 1) << 1 | 8'(k & 1), 8'h40);
        rd(8'h02, got); check("R7 abort to idle", got, pat_val(2));
        wr(8'h00, 8'h60);
        rd(8'h02, got); check("R6 still unlocked", got, 8'h00);
        wr(8'h00, 8'hF0);
      end
    end
    // R7: wrong data at the pattern address
    wr(8'h00, 8'h60); wr(8'h02, 8'h41);
    rd(8'h02, got); check("R7 wrong data aborts", got, pat_val(2));
    // R11: pattern read outside verify mode
    rd(8'h0A, got); check("R11 pattern outside verify", got, pat_val(10));

    // R6 / R11 while armed
    wr(8'h00, 8'h60);
    rd(8'h02, got); check("R6 armed status", got, 8'h00);
    rd(8'h05, got); check("R11 non-pattern in verify", got, pat_val(5));
    // R5: protect
    wr(8'h0A, 8'h40);
    rd(8'h02, got); check("R5 status locked", got, 8'h01);
    rd(8'h0E, got); check("R5 status other pattern", got, 8'h01);
    rd(8'h07, got); check("R11 non-pattern locked", got, pat_val(7));
    // R12: rdata holds without rd_en
    @(negedge clk); addr = 8'h02;
    idle(4);
    check("R12 rdata held", rdata, pat_val(7));
    // R8: end verify
    wr(8'h00, 8'hF0);
    rd(8'h02, got); check("R8 data after F0", got, pat_val(2));
    check("R8 region kept", {7'b0, in_region}, 8'h01);
    // R9: program attempt ignored
    wr(8'h00, 8'hA0); wr(8'h03, 8'h55);
    rd(8'h03, got); check("R9 program ignored", got, pat_val(3));
    wr(8'h00, 8'h60);
    rd(8'h02, got); check("R9 lock after F0", got, 8'h01);
    wr(8'h00, 8'hF0);
    // R9: survives leave and bus reset
    wr(8'h00, 8'h90); wr(8'h00, 8'h00);
    bus_reset();
    check("R1 region after bus reset", {7'b0, in_region}, 8'h00);
    wr(8'h00, 8'h88);
    wr(8'h00, 8'h60);
    rd(8'h02, got); check("R9 lock after rst_n", got, 8'h01);
    rd(8'h03, got); check("R9 data after rst_n", got, pat_val(3));

    // R10: power-on init clears lock and contents
    @(negedge clk); por_init = 1'b1;
    @(negedge clk); por_init = 1'b0;
    rd(8'h02, got); check("R10 lock cleared", got, 8'h00);
    wr(8'h00, 8'hF0);
    rd(8'h03, got); check("R10 contents blank", got, 8'hFF);
    wr(8'h00, 8'hA0); wr(8'h03, 8'h5A);
    rd(8'h03, got); check("R4 program after init", got, 8'h5A);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule